// File: doc/BRIEF.md
# Short-Cycling SAR Converter Read Controller

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. The link has an active-low select, a serial clock and a data return line. One trigger pulse starts one conversion. The block drops select, makes the serial clock by dividing the fast system clock, and shifts the returned bits in on serial clock rising edges. The first two bits of each frame are thrown away, because the converter sends a high-impedance slot and then a leading zero before its most significant bit.

A per-frame bit count lets a caller end the frame after fewer than 16 result bits. The partial result is placed in the top bits of the 16-bit two's complement output and the missing low bits are filled with zeros, so sign and scale stay correct. After each frame, select stays high for a fixed acquisition gap while the converter tracks its input. The sample rate therefore equals the trigger rate, and sparse triggers give burst-mode operation at a fixed serial clock frequency.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `cs_n` and `sclk` are 1, and `busy` and `rd_valid` are 0.
- R2: Each `sclk` phase lasts `DIV_HALF` system clocks. `sclk` is 1 whenever `cs_n` is 1. `cs_n` only falls while `sclk` is 1, and the first `sclk` fall comes `DIV_HALF` clocks after `cs_n` falls.
- R3: A `trig` sampled high while `busy` is 0 drives `cs_n` to 0 and `busy` to 1 on the next clock.
- R4: `sdi` is sampled on the cycle in which `sclk` rises. The bits from rising edges 1 and 2 are discarded. Rising edge 3 carries the result MSB (bit 15), and later edges carry the following bits in descending order.
- R5: The bit count `nbits` is latched when the frame starts. Values 1 to 16 are used as given, and 0 or any value from 17 to 31 means 16. A frame with count N has exactly N+2 `sclk` rising edges, and `cs_n` rises in the same cycle as the last one.
- R6: The result is left-aligned. Bit 15 is the first result bit, and the low 16-N bits of `rd_data` are 0. `rd_nbits` reports N.
- R7: `rd_valid` is high for exactly one cycle, the cycle in which `cs_n` rises.
- R8: After `cs_n` rises, `busy` stays 1 for exactly 3×2×`DIV_HALF` system clocks (3 serial clock periods), and no frame starts during that time.
- R9: A `trig` that arrives while `busy` is 1 is ignored and never starts a frame later.
- R10: With `trig` held high, frames run back to back and `cs_n` is high for exactly 3×2×`DIV_HALF`+1 clocks between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start of conversion request |
| nbits | input | 5 | Result bits wanted (0 or >16 means 16) |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or acquisition gap in progress |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | 16 | Left-aligned two's complement result |
| rd_nbits | output | 5 | Bit count used for `rd_data` |

## Verification
The assertions assume a synchronous reset that lasts at least one clock. They assume `trig` and `nbits` are stable at each rising edge of the system clock. They assume `sdi` changes only after `sclk` falls, the way the converter behaves. The bench converter model changes `sdi` one system clock after each `sclk` fall. All stimulus is driven on falling system clock edges. Bit counts cover all 32 codes of `nbits`, and some triggers are placed on purpose inside a running frame and inside the acquisition gap.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  // Frame sequencer states
  typedef enum logic [1:0] {
    ST_IDLE,   // select high, waiting for a trigger
    ST_SETUP,  // select low, serial clock still high
    ST_RUN,    // serial clock toggling, bits arriving
    ST_GAP     // select high, converter acquiring
  } rd_state_e;

  // Slots ahead of the result MSB: high-impedance slot and leading zero
  localparam int LEAD_SLOTS = 2;

endpackage

// File: rtl/sar_rd_tick.sv
// Phase timer: pulses tick on the last system clock of each serial half period.
module sar_rd_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_rd_capture.sv
// Shift register for result bits, plus left alignment of a short result.
module sar_rd_capture #(
  parameter int RES_W = 16,
  parameter int NB_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             sdi,
  input  logic [NB_W-1:0]  nbits,
  output logic [RES_W-1:0] word_o
);
  logic [RES_W-1:0] sh;
  logic [RES_W-1:0] nxt;

  assign nxt = {sh[RES_W-2:0], sdi};

  // Only valid in the cycle of the final shift; moves the N bits to the top
  always_comb begin
    word_o = nxt << (RES_W - int'(nbits));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh <= '0;
    end else if (shift) begin
      sh <= nxt;
    end
  end
endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl #(
  parameter int RES_W    = 16,
  parameter int DIV_HALF = 2,
  parameter int GAP_PER  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         trig,
  input  logic [$clog2(RES_W+1)-1:0]   nbits,
  input  logic                         sdi,
  output logic                         cs_n,
  output logic                         sclk,
  output logic                         busy,
  output logic                         rd_valid,
  output logic [RES_W-1:0]             rd_data,
  output logic [$clog2(RES_W+1)-1:0]   rd_nbits
);
  import sar_rd_pkg::*;

  localparam int NB_W     = $clog2(RES_W + 1);
  localparam int EDGES    = RES_W + LEAD_SLOTS;
  localparam int EDGE_W   = $clog2(EDGES + 1);
  localparam int GAP_CLKS = GAP_PER * 2 * DIV_HALF;
  localparam int GAP_W    = $clog2(GAP_CLKS + 1);

  rd_state_e         state;
  logic [NB_W-1:0]   nlat;
  logic [EDGE_W-1:0] edge_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [NB_W-1:0]   n_req;
  logic              tick;
  logic              rise_now;
  logic              last_edge;
  logic              shift_en;
  logic              start;
  logic [RES_W-1:0]  word;

  // Out-of-range requests fall back to a full-length frame
  assign n_req = ((nbits == '0) || (int'(nbits) > RES_W)) ? NB_W'(RES_W) : nbits;

  assign start     = (state == ST_IDLE) && trig;
  assign rise_now  = (state == ST_RUN) && tick && !sclk;
  assign last_edge = rise_now &&
                     (edge_cnt == (EDGE_W'(nlat) + EDGE_W'(LEAD_SLOTS - 1)));
  assign shift_en  = rise_now && (edge_cnt >= EDGE_W'(LEAD_SLOTS));

  sar_rd_tick #(.HALF(DIV_HALF)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  ((state == ST_SETUP) || (state == ST_RUN)),
    .tick (tick)
  );

  sar_rd_capture #(.RES_W(RES_W), .NB_W(NB_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .shift  (shift_en),
    .sdi    (sdi),
    .nbits  (nlat),
    .word_o (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_nbits <= '0;
      nlat     <= '0;
      edge_cnt <= '0;
      gap_cnt  <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            state    <= ST_SETUP;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            nlat     <= n_req;
            edge_cnt <= '0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            sclk  <= 1'b0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (sclk) begin
              sclk <= 1'b0;
            end else begin
              sclk     <= 1'b1;
              edge_cnt <= edge_cnt + 1'b1;
              if (last_edge) begin
                cs_n     <= 1'b1;
                rd_valid <= 1'b1;
                rd_data  <= word;
                rd_nbits <= nlat;
                gap_cnt  <= '0;
                state    <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CLKS - 1)) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_rd_ctrl_chk.sv
module sar_rd_ctrl_chk #(
  parameter int RES_W    = 16,
  parameter int DIV_HALF = 2,
  parameter int GAP_PER  = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_n,
  input logic                       sclk,
  input logic                       busy,
  input logic                       rd_valid,
  input logic [RES_W-1:0]           rd_data,
  input logic [$clog2(RES_W+1)-1:0] rd_nbits
);
  localparam int GAP_CLKS = GAP_PER * 2 * DIV_HALF;
  localparam int LEAD     = 2;
  localparam logic [RES_W-1:0] ONES = '1;

  logic sclk_q, cs_q;
  int   rise_cnt;
  int   hi_cnt;
  logic rise;

  assign rise = sclk && !sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b1;
      cs_q     <= 1'b1;
      rise_cnt <= 0;
      hi_cnt   <= GAP_CLKS + 1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_q && !cs_n) rise_cnt <= 0;
      else if (!cs_q && rise) rise_cnt <= rise_cnt + 1;
      if (!cs_n) hi_cnt <= 0;
      else if (hi_cnt < GAP_CLKS + 1) hi_cnt <= hi_cnt + 1;
    end
  end

  a_r2_cs_falls_sclk_high: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk && $past(sclk)));
  a_r2_sclk_idles_high: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);
  a_r3_busy_in_frame: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
  a_r5_edge_count: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rise_cnt + 1 == int'(rd_nbits) + LEAD));
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data & (ONES >> rd_nbits)) == '0));
  a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_nbits != '0 && int'(rd_nbits) <= RES_W));
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  a_r7_valid_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(cs_n));
  a_r8_gap_kept: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= GAP_CLKS));
endmodule

bind sar_rd_ctrl sar_rd_ctrl_chk #(
  .RES_W(RES_W), .DIV_HALF(DIV_HALF), .GAP_PER(GAP_PER)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .busy(busy),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_nbits(rd_nbits)
);

// File: tb/test_sar_rd_ctrl.sv
module test_sar_rd_ctrl;
  localparam int RES_W    = 16;
  localparam int H        = 2;
  localparam int GAP_CLKS = 3 * 2 * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [4:0]  nbits = 5'd16;
  logic        sdi = 1'b1;
  logic        cs_n, sclk, busy, rd_valid;
  logic [15:0] rd_data;
  logic [4:0]  rd_nbits;

  int checks = 0;
  int errors = 0;

  sar_rd_ctrl #(.RES_W(RES_W), .DIV_HALF(H), .GAP_PER(3)) i_sar_rd_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .nbits(nbits), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_nbits(rd_nbits)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff_n(input int n);
    return (n == 0 || n > RES_W) ? RES_W : n;
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] w, input int n);
    return (w >> (16 - n)) << (16 - n);
  endfunction

  // Converter model: bit for rising edge k is driven after falling edge k
  logic [15:0] next_word = 16'h0;
  logic [15:0] adc_word  = 16'h0;
  int          nfall = 0;
  logic        m_sclk_q = 1'b1, m_cs_q = 1'b1;
  always @(posedge clk) begin
    if (m_cs_q && !cs_n) begin
      adc_word = next_word;
      nfall = 0;
      sdi <= 1'b1;
    end else if (!cs_n && m_sclk_q && !sclk) begin
      nfall = nfall + 1;
      if (nfall == 1) sdi <= 1'b1;
      else if (nfall == 2) sdi <= 1'b0;
      else if (nfall <= 18) sdi <= adc_word[18 - nfall];
      else sdi <= 1'b1;
    end
    m_sclk_q <= sclk;
    m_cs_q   <= cs_n;
  end

  // Port monitor
  logic p_sclk = 1'b1, p_cs = 1'b1;
  int rises = 0, frames = 0, hi_run = 0, last_hi = 0, plen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_cs && !cs_n) begin
        check(sclk, "R2 select fell with sclk low", sclk, 1);
        frames++;
        rises = 0;
        last_hi = hi_run;
        hi_run = 0;
        plen = 1;
      end else if (sclk != p_sclk) begin
        if (!p_cs) check(plen == H, "R2 sclk phase length", plen, H);
        if (sclk && !p_cs) rises++;
        plen = 1;
      end else begin
        plen++;
      end
      if (cs_n) begin
        hi_run++;
        check(sclk, "R2 sclk high while idle", sclk, 1);
      end
    end
    p_sclk = sclk;
    p_cs = cs_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run_frame(input int n_in, input logic [15:0] w, input bit poke);
    int n, k, f0;
    n = eff_n(n_in);
    while (busy) @(negedge clk);
    nbits = 5'(n_in);
    next_word = w;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(!cs_n && busy, "R3 frame start", {busy, cs_n}, 2);
    k = 0;
    while (!rd_valid && k < 200) begin
      @(negedge clk);
      k++;
      if (poke && k == 5) trig = 1'b1;   // R9: trigger inside a frame
      if (poke && k == 6) trig = 1'b0;
    end
    check(rd_data == exp_word(w, n), "R4 R6 result bits", rd_data, exp_word(w, n));
    check(int'(rd_nbits) == n, "R5 R6 reported count", rd_nbits, n);
    check(cs_n, "R7 select high at strobe", cs_n, 1);
    f0 = frames;
    @(negedge clk);
    check(!rd_valid, "R7 strobe one cycle", rd_valid, 0);
    check(rises == n + 2, "R5 rising edge count", rises, n + 2);
    k = 1;
    if (poke) trig = 1'b1;               // R9: trigger inside the gap
    @(negedge clk);
    trig = 1'b0;
    k++;
    while (busy && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(k == GAP_CLKS, "R8 gap length", k, GAP_CLKS);
    if (poke) begin
      repeat (6) @(negedge clk);
      check(cs_n && frames == f0, "R9 late trigger ignored", frames, f0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check(cs_n && sclk && !busy && !rd_valid, "R1 reset outputs",
          {cs_n, sclk, busy, rd_valid}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && sclk && !busy && !rd_valid, "R1 after reset",
          {cs_n, sclk, busy, rd_valid}, 4'b1100);

    run_frame(16, 16'h8000, 1'b0);
    run_frame(1,  16'h7FFF, 1'b1);
    run_frame(0,  16'h8001, 1'b0);
    run_frame(17, 16'hA5C3, 1'b1);
    run_frame(31, 16'h1234, 1'b0);
    run_frame(5,  16'hFFFF, 1'b0);
    run_frame(15, 16'h0001, 1'b0);

    for (int i = 0; i < 150; i++) begin
      run_frame(int'($urandom % 32), 16'($urandom), ($urandom % 4) == 0);
      repeat ($urandom % 5) @(negedge clk);
    end

    // R10: trigger held high, back-to-back frames
    while (busy) @(negedge clk);
    begin
      int f0;
      f0 = frames;
      nbits = 5'd16;
      trig = 1'b1;
      while (frames < f0 + 3) @(negedge clk);
      trig = 1'b0;
      check(last_hi == GAP_CLKS + 1, "R10 back-to-back select high time",
            last_hi, GAP_CLKS + 1);
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule